// File: doc/BRIEF.md
# Rate One-Half Convolutional Encoder

This block is a streaming forward-error-correction encoder. Every accepted information bit produces a pair of coded bits in the same cycle. The pair is formed from the bit itself and from a two-stage memory of the two bits before it. The memory therefore gives four states. The code has constraint length three and fixed generator taps. The first coded bit sums the current bit and both stored bits modulo 2. The second coded bit sums the current bit and the older stored bit only.

Data enters and leaves through valid/ready handshakes. The input side is passed straight through to the output side, so a step happens only in a cycle where the consumer is ready. To terminate a message, a flush request feeds two zero bits of its own through the encoder, which drives the memory back to the all-zero state. A synchronous clear empties the memory at once and cancels any flush in progress.

Top module: `conv_enc_r12`

## Requirements
- R1: The coded bit `out_code[1]` equals x XOR D1 XOR D2. Here x is the bit being encoded, D1 is the previous accepted bit and D2 is the bit accepted before D1.
- R2: The coded bit `out_code[0]` equals x XOR D2.
- R3: A step happens in a cycle with `out_valid` and `out_ready` both high. After a step, D1 holds that step's x and D2 holds the old D1. In a cycle without a step, both stages keep their values. The outputs are always computed from the stage values held before the shift.
- R4: When neither a flush nor a clear is active, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. The bit encoded is `in_bit`.
- R5: A `flush_req` that is sampled at a clock edge while no flush is running and `clr` is low starts a flush. The next two steps encode x = 0. During the flush, `out_valid` is high and `in_ready` is low. After the second flush step, both stages are 0 and `in_ready` again follows `out_ready`.
- R6: A `flush_req` that arrives while a flush is running is ignored. Exactly two zero steps take place in total.
- R7: While `clr` is high, `out_valid` and `in_ready` are low. At the next edge, both stages are cleared and any running flush is cancelled.
- R8: After reset, both stages are 0 and no flush is running.
- R9: Starting from state 00, the input 1 1 1 0 0 0 gives the pairs {out_code[1],out_code[0]} = 11 01 10 01 11 00. The input 1 0 1 0 0 0 gives 11 10 00 10 11 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of the encoder memory |
| flush_req | input | 1 | Request to insert two terminating zero bits |
| in_valid | input | 1 | Information bit is present |
| in_ready | output | 1 | Information bit is taken this cycle |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Coded pair is present |
| out_ready | input | 1 | Consumer takes the coded pair |
| out_code | output | 2 | Coded pair: bit 1 is the first generator, bit 0 is the second |

## Verification
The bench first sweeps all eight combinations of stored state and input bit, which separates the two generator equations from each other and from wrong tap choices. Two fixed six-bit messages are then compared against their known pair streams; these expose a wrong shift direction or outputs taken after the shift. A long pseudo-random run then mixes stalls, flushes, flush requests during a flush and clears. It is checked cycle by cycle against an arithmetic model of the state, and it tells apart stall handling, termination length and the priority of the clear.

// File: rtl/cenc_pkg.sv
package cenc_pkg;
   localparam int CENC_MEM  = 2;
   localparam int CENC_K    = CENC_MEM + 1;
   localparam int CENC_OUTS = 2;
   // tap vector order: bit K-1 = current bit, bit 1 = D1, bit 0 = D2
   localparam logic [CENC_K-1:0] CENC_G_HI = 3'b111;
   localparam logic [CENC_K-1:0] CENC_G_LO = 3'b101;
   localparam logic [CENC_OUTS*CENC_K-1:0] CENC_TAPS = {CENC_G_HI, CENC_G_LO};
endpackage

// File: rtl/cenc_shift.sv
module cenc_shift #(
   parameter int MEM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           adv,
   input  logic           x,
   output logic [MEM-1:0] st
);
   generate
      if (MEM < 1) begin : g_bad_mem
         $error("cenc_shift: MEM must be at least 1");
      end
   endgenerate

   // st[MEM-1] is the newest stored bit (D1), st[0] the oldest (D2)
   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st <= '0;
      end else if (adv) begin
         if (MEM == 1) st <= x;
         else          st <= {x, st[MEM-1:1]};
      end
   end

   AST_SHIFT_TAKES_X: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> (st[MEM-1] == $past(x))); // R3
   AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(st)); // R3
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (st == '0)); // R7
endmodule

// File: rtl/cenc_parity.sv
module cenc_parity #(
   parameter int K    = 3,
   parameter int OUTS = 2,
   parameter logic [OUTS*K-1:0] TAPS = 6'b111101
) (
   input  logic [K-1:0]    vec,
   output logic [OUTS-1:0] code
);
   generate
      for (genvar j = 0; j < OUTS; j++) begin : g_out
         if (TAPS[j*K + K-1] != 1'b1) begin : g_bad_tap
            $error("cenc_parity: every generator must tap the current bit");
         end
         assign code[j] = ^(vec & TAPS[j*K +: K]);
      end
   endgenerate
endmodule

// File: rtl/cenc_flush.sv
module cenc_flush #(
   parameter bit FLUSH_EN = 1'b1,
   parameter int LEN      = 2,
   localparam int CW      = $clog2(LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          req,
   input  logic          take,
   output logic          busy,
   output logic [CW-1:0] left
);
   generate
      if (FLUSH_EN) begin : g_flush
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               cnt <= '0;
            end else if (cnt == '0) begin
               if (req) cnt <= CW'(LEN);
            end else if (take) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign left = cnt;
         assign busy = (cnt != '0);

         AST_FLUSH_NOT_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !take && !clr) |=> $stable(cnt)); // R6
      end else begin : g_noflush
         assign left = '0;
         assign busy = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/conv_enc_r12.sv
module conv_enc_r12
   import cenc_pkg::*;
#(
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       flush_req,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic       in_bit,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [1:0] out_code
);
   localparam int FCW = $clog2(CENC_MEM + 1);

   generate
      if (CENC_OUTS != 2) begin : g_bad_outs
         $error("conv_enc_r12: rate one-half needs two outputs");
      end
   endgenerate

   logic                flushing;
   logic [FCW-1:0]      flush_left;
   logic                step;
   logic                x_eff;
   logic [CENC_MEM-1:0] st;

   assign out_valid = !clr && (flushing || in_valid);
   assign in_ready  = !clr && !flushing && out_ready;
   assign step      = out_valid && out_ready;
   assign x_eff     = flushing ? 1'b0 : in_bit;

   cenc_flush #(.FLUSH_EN(FLUSH_EN), .LEN(CENC_MEM)) u_flush (
      .clk(clk), .rst_n(rst_n), .clr(clr), .req(flush_req),
      .take(step), .busy(flushing), .left(flush_left)
   );

   cenc_shift #(.MEM(CENC_MEM)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .adv(step), .x(x_eff), .st(st)
   );

   cenc_parity #(.K(CENC_K), .OUTS(CENC_OUTS), .TAPS(CENC_TAPS)) u_par (
      .vec({x_eff, st}), .code(out_code)
   );

   AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      flushing |-> (!in_ready && out_valid == !clr)); // R5
   AST_FLUSH_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_left == FCW'(1) && step && !clr) |=> (st == '0 && !flushing)); // R5
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> (!out_valid && !in_ready)); // R7
   AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (out_ready && in_valid == out_valid)); // R4
endmodule

// File: tb/conv_enc_r12_tb.sv
module conv_enc_r12_tb;
   logic clk = 1'b0;
   logic rst_n, clr, flush_req, in_valid, in_bit, out_ready;
   logic in_ready, out_valid;
   logic [1:0] out_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   bit m_d1, m_d2;
   int m_cnt;

   always #10 clk = ~clk;

   conv_enc_r12 u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .flush_req(flush_req),
      .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
      .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive, check combinational outputs, update model at edge
   task automatic cyc(input bit iv, input bit ib, input bit ordy, input bit fr,
                      input bit cl, output logic [1:0] seen);
      bit fl, ev, er, x;
      logic [1:0] ec;
      @(negedge clk);
      in_valid = iv; in_bit = ib; out_ready = ordy; flush_req = fr; clr = cl;
      #4;
      fl = (m_cnt != 0);
      ev = !cl && (fl || iv);
      er = !cl && !fl && ordy;
      x  = fl ? 1'b0 : ib;
      ec = {x ^ m_d1 ^ m_d2, x ^ m_d2};
      seen = out_code;
      chk(out_valid == ev, cl ? "R7 out_valid" : (fl ? "R5 out_valid" : "R4 out_valid"),
          out_valid, ev);
      chk(in_ready == er, cl ? "R7 in_ready" : (fl ? "R5 in_ready" : "R4 in_ready"),
          in_ready, er);
      if (ev) begin
         chk(out_code[1] == ec[1], "R1 y1", out_code[1], ec[1]);
         chk(out_code[0] == ec[0], "R2 y2", out_code[0], ec[0]);
      end
      @(posedge clk);
      if (cl) begin
         m_d1 = 0; m_d2 = 0; m_cnt = 0;
      end else begin
         if (ev && ordy) begin
            m_d2 = m_d1; m_d1 = x;
            if (fl) m_cnt--;
         end
         if (!fl && fr) m_cnt = 2;
      end
   endtask

   task automatic run_seq(input bit [5:0] bits, input bit [11:0] exp, input string tag);
      logic [1:0] s;
      cyc(0, 0, 1, 0, 1, s);
      for (int i = 5; i >= 0; i--) begin
         cyc(1, bits[i], 1, 0, 0, s);
         chk(s == exp[2*i +: 2], tag, s, exp[2*i +: 2]);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [1:0] s;
      logic [15:0] lf;
      rst_n = 0; clr = 0; flush_req = 0; in_valid = 0; in_bit = 0; out_ready = 1;
      m_d1 = 0; m_d2 = 0; m_cnt = 0;
      repeat (3) @(posedge clk);
      #1 chk(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
      @(negedge clk) rst_n = 1;
      // R8: state zero and no flush right after reset
      cyc(1, 0, 1, 0, 0, s);
      chk(s == 2'b00, "R8 state after reset", s, 0);

      // R1 R2: all states and inputs
      for (int st = 0; st < 4; st++) begin
         for (int xb = 0; xb < 2; xb++) begin
            cyc(0, 0, 1, 0, 1, s);
            cyc(1, st[0], 1, 0, 0, s);   // becomes D2
            cyc(1, st[1], 1, 0, 0, s);   // becomes D1
            cyc(1, xb[0], 1, 0, 0, s);
            chk(s == {xb[0] ^ st[1] ^ st[0], xb[0] ^ st[0]}, "R1 R2 sweep", s,
                {xb[0] ^ st[1] ^ st[0], xb[0] ^ st[0]});
         end
      end

      // R9 known messages
      run_seq(6'b111000, 12'b11_01_10_01_11_00, "R9 seq 111000");
      run_seq(6'b101000, 12'b11_10_00_10_11_00, "R9 seq 101000");

      // R3 stall holds state: load 1, stall, then x=0 shows D1
      cyc(0, 0, 1, 0, 1, s);
      cyc(1, 1, 1, 0, 0, s);
      cyc(1, 0, 0, 0, 0, s);
      cyc(0, 1, 1, 0, 0, s);
      cyc(1, 0, 1, 0, 0, s);
      chk(s == 2'b10, "R3 stall holds D1", s, 2);

      // R5 R6 flush with extra request during flush
      cyc(1, 1, 1, 1, 0, s);
      cyc(0, 1, 1, 1, 0, s);
      chk(in_ready == 1'b0, "R5 flush blocks input", in_ready, 0);
      cyc(0, 1, 1, 1, 0, s);
      cyc(1, 0, 1, 0, 0, s);
      chk(in_ready == 1'b1 && s == 2'b00, "R6 flush ends after two", {in_ready, s}, 4);

      // R7 clear aborts flush
      cyc(1, 1, 1, 1, 0, s);
      cyc(0, 0, 1, 0, 1, s);
      cyc(1, 0, 1, 0, 0, s);
      chk(s == 2'b00 && in_ready == 1'b1, "R7 clear aborts flush", {in_ready, s}, 4);

      // pseudo-random mix
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc(lf[0], lf[1], lf[2] | lf[3], (lf[7:4] == 4'h3), (lf[11:8] == 4'h5), s);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule